// File: doc/BRIEF.md
# Command-Byte Serial Register Interface

This block is the serial control port of a low-rate converter. A host drives an SPI mode 0 bus (clock idle low, data sampled on the rising clock edge, changed on the falling edge). Each transaction opens with one command byte. That byte either fires a one-cycle strobe toward the converter core, to start a conversion or to power down, or it opens a read or write of one register in a small bank. The bank holds byte-wide status and control registers and 24-bit result and calibration words.

The converter core hands finished results in on a parallel bus with a valid strobe. The block keeps those results and the calibration values and shows them to the host. It does not compute them. A control register drives the direction and the output level of four general-purpose pins. The serial pins are sampled with the system clock through a synchronizer, so the serial clock must run well below the system clock.

Top module: `cmd_spi_regif`

## Requirements
- R1: After reset every writable register, the result word, `dout`, `conv_start` and `pwr_down` are zero.
- R2: Command byte bits, MSB first: bit 7 is a start bit that must be 1, bit 6 is MODE, bit 5 is the action select, bits 4:1 are the register address and bit 0 is read (1) or write (0). If the start bit is 0, the rest of the transaction up to chip-select release has no effect.
- R3: With MODE = 0, bit 5 = 0 raises `conv_start` and bit 5 = 1 raises `pwr_down`, each for exactly one clock. No data phase follows, so later bits in the same transaction write nothing.
- R4: Addresses 0x4 to 0x8 move 24 data bits and all other addresses move 8. Data goes MSB first in both directions. The first read bit is on `dout` before the first rising clock edge of the data phase.
- R5: CTRL_A (0x1), CTRL_B (0x2), CTRL_C (0x3) and the calibration words at 0x5 to 0x8 read back what was last written. CTRL_A and CTRL_C appear on `ctrl_a` and `ctrl_c`. The word at address 0x5+i appears on `cal_words[24*i+23 : 24*i]`.
- R6: Status (0x0) reads {`sys_gain_ovr`, 7'b0}. Status and the result word (0x4) ignore writes.
- R7: Addresses 0x9 to 0xF read as zero and ignore writes.
- R8: CTRL_B bits 7:4 drive `gpio_dir` and bits 3:0 drive `gpio_out`.
- R9: Raising `cs_n` before the last data bit ends the transaction and writes no register. The next transaction starts with a new command byte.
- R10: A `result_valid` strobe loads `result_data` into the result word. If the strobe comes while the result word is being read out, the value is held back and loaded when that read ends or is aborted, so all 24 bits read come from one result.
- R11: `dout` is 0 outside the data phase of a read, including during the command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host, idle low |
| cs_n | input | 1 | Active-low chip select |
| din | input | 1 | Serial data from the host |
| dout | output | 1 | Serial data to the host |
| result_data | input | 24 | Conversion result from the core |
| result_valid | input | 1 | One-cycle strobe qualifying result_data |
| sys_gain_ovr | input | 1 | Gain-calibration overrange flag, shown in status bit 7 |
| gpio_dir | output | 4 | Pin direction, 1 = output |
| gpio_out | output | 4 | Pin output level |
| ctrl_a | output | 8 | Control register A |
| ctrl_c | output | 8 | Control register C |
| cal_words | output | 96 | Four packed 24-bit calibration words |
| conv_start | output | 1 | One-cycle conversion start strobe |
| pwr_down | output | 1 | One-cycle power-down strobe |

## Verification
A new conversion result can arrive in the same cycle that a result-word read ends, which is also the cycle the hold-back is released. The bench reads the result word again and again and fires `result_valid` once in each run, during a different data bit every time, including the final bit whose rising edge closes the read. It also aborts one read partway through. In every case the read must return the old word whole and the next read must return the new one.

// File: rtl/cmd_spi_pkg.sv
package cmd_spi_pkg;
    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 24;
    localparam int ADDR_W   = 4;
    localparam int NUM_CAL  = 4;
    localparam int GPIO_N   = 4;
    localparam int BCNT_W   = $clog2(WORD_W);
    localparam int CAL_BASE = 5;

    localparam logic [ADDR_W-1:0] A_STAT   = 4'h0;
    localparam logic [ADDR_W-1:0] A_CTRLA  = 4'h1;
    localparam logic [ADDR_W-1:0] A_CTRLB  = 4'h2;
    localparam logic [ADDR_W-1:0] A_CTRLC  = 4'h3;
    localparam logic [ADDR_W-1:0] A_RESULT = 4'h4;

    typedef enum logic [1:0] {
        ST_CMD,
        ST_XFER,
        ST_DONE
    } xfer_state_e;

    // words from the result register through the last calibration word
    function automatic logic is_wide(input logic [ADDR_W-1:0] a);
        return (a >= A_RESULT) && (a <= ADDR_W'(CAL_BASE + NUM_CAL - 1));
    endfunction
endpackage

// File: rtl/cmd_spi_sync.sv
module cmd_spi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic din,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_act,
    output logic din_s
);
    typedef struct packed {
        logic [STAGES-1:0] sclk_sh;
        logic [STAGES-1:0] cs_sh;
        logic [STAGES-1:0] din_sh;
        logic              sclk_last;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d           = q;
        d.sclk_sh   = {q.sclk_sh[STAGES-2:0], sclk};
        d.cs_sh     = {q.cs_sh[STAGES-2:0], cs_n};
        d.din_sh    = {q.din_sh[STAGES-2:0], din};
        d.sclk_last = q.sclk_sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sclk_sh   <= '0;
            q.cs_sh     <= '1;
            q.din_sh    <= '0;
            q.sclk_last <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sclk_rise = q.sclk_sh[STAGES-1] & ~q.sclk_last;
    assign sclk_fall = ~q.sclk_sh[STAGES-1] & q.sclk_last;
    assign cs_act    = ~q.cs_sh[STAGES-1];
    assign din_s     = q.din_sh[STAGES-1];
endmodule

// File: rtl/cmd_spi_bank.sv
module cmd_spi_bank
    import cmd_spi_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [WORD_W-1:0]         wr_word,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [WORD_W-1:0]         rd_word,
    input  logic                      hold,
    input  logic                      res_valid,
    input  logic [WORD_W-1:0]         res_data,
    input  logic                      ovr_flag,
    output logic [WORD_W-1:0]         result_word,
    output logic [BYTE_W-1:0]         ctrl_a,
    output logic [BYTE_W-1:0]         ctrl_b,
    output logic [BYTE_W-1:0]         ctrl_c,
    output logic [NUM_CAL*WORD_W-1:0] cal_words
);
    typedef struct packed {
        logic [BYTE_W-1:0]              ctrl_a;
        logic [BYTE_W-1:0]              ctrl_b;
        logic [BYTE_W-1:0]              ctrl_c;
        logic [WORD_W-1:0]              result;
        logic [WORD_W-1:0]              pend;
        logic                           pend_v;
        logic [NUM_CAL-1:0][WORD_W-1:0] cal;
    } bank_t;

    bank_t q, d;

    always_comb begin
        d = q;
        if (wr_en) begin
            case (wr_addr)
                A_CTRLA: d.ctrl_a = wr_word[BYTE_W-1:0];
                A_CTRLB: d.ctrl_b = wr_word[BYTE_W-1:0];
                A_CTRLC: d.ctrl_c = wr_word[BYTE_W-1:0];
                default: ;
            endcase
            for (int i = 0; i < NUM_CAL; i++) begin
                if (wr_addr == ADDR_W'(CAL_BASE + i)) d.cal[i] = wr_word;
            end
        end
        // a fresh result wins over an older held one
        if (res_valid) begin
            if (hold) begin
                d.pend   = res_data;
                d.pend_v = 1'b1;
            end else begin
                d.result = res_data;
                d.pend_v = 1'b0;
            end
        end else if (q.pend_v && !hold) begin
            d.result = q.pend;
            d.pend_v = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rd_word = '0;
        case (rd_addr)
            A_STAT:   rd_word[BYTE_W-1] = ovr_flag;
            A_CTRLA:  rd_word[BYTE_W-1:0] = q.ctrl_a;
            A_CTRLB:  rd_word[BYTE_W-1:0] = q.ctrl_b;
            A_CTRLC:  rd_word[BYTE_W-1:0] = q.ctrl_c;
            A_RESULT: rd_word = q.result;
            default: ;
        endcase
        for (int i = 0; i < NUM_CAL; i++) begin
            if (rd_addr == ADDR_W'(CAL_BASE + i)) rd_word = q.cal[i];
        end
    end

    for (genvar g = 0; g < NUM_CAL; g++) begin : g_cal
        assign cal_words[g*WORD_W +: WORD_W] = q.cal[g];
    end

    assign result_word = q.result;
    assign ctrl_a      = q.ctrl_a;
    assign ctrl_b      = q.ctrl_b;
    assign ctrl_c      = q.ctrl_c;
endmodule

// File: rtl/cmd_spi_regif.sv
module cmd_spi_regif
    import cmd_spi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sclk,
    input  logic                      cs_n,
    input  logic                      din,
    output logic                      dout,
    input  logic [WORD_W-1:0]         result_data,
    input  logic                      result_valid,
    input  logic                      sys_gain_ovr,
    output logic [GPIO_N-1:0]         gpio_dir,
    output logic [GPIO_N-1:0]         gpio_out,
    output logic [BYTE_W-1:0]         ctrl_a,
    output logic [BYTE_W-1:0]         ctrl_c,
    output logic [NUM_CAL*WORD_W-1:0] cal_words,
    output logic                      conv_start,
    output logic                      pwr_down
);
    localparam logic [BCNT_W-1:0] LAST_NARROW = BCNT_W'(BYTE_W - 1);
    localparam logic [BCNT_W-1:0] LAST_WIDE   = BCNT_W'(WORD_W - 1);

    typedef struct packed {
        xfer_state_e       st;
        logic [BCNT_W-1:0] bcnt;
        logic [WORD_W-1:0] sh;
        logic [ADDR_W-1:0] addr;
        logic              rd;
        logic              wide;
        logic              prime;
        logic              dout;
        logic              conv;
        logic              pdn;
    } fsm_t;

    fsm_t q, d;

    logic              sclk_rise, sclk_fall, cs_act, din_s;
    logic              wr_en, hold;
    logic [WORD_W-1:0] wr_word, rd_word, result_word, load_word;
    logic [BYTE_W-1:0] cmd_byte, ctrl_b;
    logic [BCNT_W-1:0] last_bit;

    cmd_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .din       (din),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_act    (cs_act),
        .din_s     (din_s)
    );

    assign cmd_byte  = {q.sh[BYTE_W-2:0], din_s};
    assign wr_word   = {q.sh[WORD_W-2:0], din_s};
    assign last_bit  = q.wide ? LAST_WIDE : LAST_NARROW;
    assign load_word = q.wide ? rd_word : {rd_word[BYTE_W-1:0], {(WORD_W-BYTE_W){1'b0}}};
    assign hold      = (q.st == ST_XFER) && q.rd && (q.addr == A_RESULT);

    always_comb begin
        d      = q;
        d.conv = 1'b0;
        d.pdn  = 1'b0;
        wr_en  = 1'b0;
        if (!cs_act) begin
            d.st    = ST_CMD;
            d.bcnt  = '0;
            d.dout  = 1'b0;
            d.prime = 1'b0;
        end else begin
            case (q.st)
                ST_CMD: begin
                    if (sclk_rise) begin
                        d.sh   = wr_word;
                        d.bcnt = q.bcnt + 1'b1;
                        if (q.bcnt == LAST_NARROW) begin
                            d.bcnt = '0;
                            d.st   = ST_DONE;
                            if (cmd_byte[7]) begin
                                if (!cmd_byte[6]) begin
                                    d.conv = !cmd_byte[5];
                                    d.pdn  = cmd_byte[5];
                                end else begin
                                    d.st    = ST_XFER;
                                    d.addr  = cmd_byte[4:1];
                                    d.rd    = cmd_byte[0];
                                    d.wide  = is_wide(cmd_byte[4:1]);
                                    d.prime = cmd_byte[0];
                                end
                            end
                        end
                    end
                end
                ST_XFER: begin
                    if (sclk_fall && q.rd) begin
                        if (q.prime) begin
                            d.sh    = load_word;
                            d.dout  = load_word[WORD_W-1];
                            d.prime = 1'b0;
                        end else begin
                            d.sh   = {q.sh[WORD_W-2:0], 1'b0};
                            d.dout = q.sh[WORD_W-2];
                        end
                    end
                    if (sclk_rise) begin
                        if (!q.rd) d.sh = wr_word;
                        d.bcnt = q.bcnt + 1'b1;
                        if (q.bcnt == last_bit) begin
                            wr_en  = !q.rd;
                            d.st   = ST_DONE;
                            d.dout = 1'b0;
                        end
                    end
                end
                default: d.dout = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_CMD;
        end else begin
            q <= d;
        end
    end

    cmd_spi_bank u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (q.addr),
        .wr_word     (wr_word),
        .rd_addr     (q.addr),
        .rd_word     (rd_word),
        .hold        (hold),
        .res_valid   (result_valid),
        .res_data    (result_data),
        .ovr_flag    (sys_gain_ovr),
        .result_word (result_word),
        .ctrl_a      (ctrl_a),
        .ctrl_b      (ctrl_b),
        .ctrl_c      (ctrl_c),
        .cal_words   (cal_words)
    );

    assign gpio_dir   = ctrl_b[BYTE_W-1 -: GPIO_N];
    assign gpio_out   = ctrl_b[GPIO_N-1:0];
    assign dout       = q.dout;
    assign conv_start = q.conv;
    assign pwr_down   = q.pdn;
endmodule

// File: rtl/cmd_spi_regif_chk.sv
module cmd_spi_regif_chk
    import cmd_spi_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              conv_start,
    input logic              pwr_down,
    input logic              wr_en,
    input logic              cs_act,
    input logic              hold,
    input logic              dout,
    input logic [WORD_W-1:0] result_word,
    input logic [GPIO_N-1:0] gpio_dir
);
    // R3
    conv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(conv_start && pwr_down));
    // R9
    wr_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> cs_act);
    // R10
    result_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(result_word));
    // R11
    dout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !dout);
    // R8
    gpio_dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(gpio_dir));
endmodule

bind cmd_spi_regif cmd_spi_regif_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .conv_start  (conv_start),
    .pwr_down    (pwr_down),
    .wr_en       (wr_en),
    .cs_act      (cs_act),
    .hold        (hold),
    .dout        (dout),
    .result_word (result_word),
    .gpio_dir    (gpio_dir)
);

// File: tb/cmd_spi_regif_test.sv
module cmd_spi_regif_test;
    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, cs_n = 1'b1, din = 1'b0;
    logic        dout;
    logic [23:0] result_data = '0;
    logic        result_valid = 1'b0;
    logic        sys_gain_ovr = 1'b0;
    logic [3:0]  gpio_dir, gpio_out;
    logic [7:0]  ctrl_a, ctrl_c;
    logic [95:0] cal_words;
    logic        conv_start, pwr_down;

    int checks = 0;
    int fails  = 0;
    int n_conv = 0;
    int n_pdn  = 0;
    logic [23:0] mdl [16];
    logic [23:0] mdl_result = '0;

    always #10 clk = ~clk;

    cmd_spi_regif uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
        .dout(dout), .result_data(result_data), .result_valid(result_valid),
        .sys_gain_ovr(sys_gain_ovr), .gpio_dir(gpio_dir), .gpio_out(gpio_out),
        .ctrl_a(ctrl_a), .ctrl_c(ctrl_c), .cal_words(cal_words),
        .conv_start(conv_start), .pwr_down(pwr_down)
    );

    always @(posedge clk) begin
        if (conv_start) n_conv <= n_conv + 1;
        if (pwr_down)   n_pdn  <= n_pdn + 1;
    end

    task automatic chk(input string req, input logic [95:0] got, input logic [95:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int width_of(input int a);
        return (a >= 4 && a <= 8) ? 24 : 8;
    endfunction

    function automatic logic [7:0] reg_cmd(input logic rd, input int a);
        return {2'b11, 1'b0, 4'(a), rd};
    endfunction

    function automatic logic [23:0] expect_read(input int a);
        if (a == 0) return {16'h0, sys_gain_ovr, 7'h0};
        if (a == 4) return mdl_result;
        if (a >= 1 && a <= 8) return mdl[a];
        return 24'h0;
    endfunction

    task automatic model_write(input int a, input logic [23:0] v);
        if (a >= 1 && a <= 3) mdl[a] = {16'h0, v[7:0]};
        else if (a >= 5 && a <= 8) mdl[a] = v;
    endtask

    task automatic xfer(input logic [7:0] cmd, input int ndata, input logic [23:0] wdat,
                        input int pulse_bit, input logic [23:0] pulse_val, input int abort_bit,
                        output logic [23:0] rdat, output logic cmd_hi);
        int total;
        total  = 8 + ndata;
        rdat   = '0;
        cmd_hi = 1'b0;
        @(negedge clk) cs_n = 1'b0;
        wclk(HALF);
        for (int i = 0; i < total; i++) begin
            if (i == abort_bit) break;
            din = (i < 8) ? cmd[7-i] : wdat[ndata-1-(i-8)];
            wclk(HALF);
            if (i < 8) cmd_hi = cmd_hi | dout;
            else       rdat = {rdat[22:0], dout};
            sclk = 1'b1;
            if (i == pulse_bit) begin
                wclk(HALF/2);
                result_data  = pulse_val;
                result_valid = 1'b1;
                wclk(1);
                result_valid = 1'b0;
                wclk(HALF - HALF/2 - 1);
            end else begin
                wclk(HALF);
            end
            sclk = 1'b0;
        end
        wclk(HALF);
        cs_n = 1'b1;
        din  = 1'b0;
        wclk(2*HALF);
    endtask

    task automatic reg_write(input int a, input logic [23:0] v);
        logic [23:0] r; logic h;
        xfer(reg_cmd(1'b0, a), width_of(a), v, -1, '0, -1, r, h);
        model_write(a, v);
    endtask

    task automatic reg_read(input int a, output logic [23:0] r, output logic h);
        xfer(reg_cmd(1'b1, a), width_of(a), '0, -1, '0, -1, r, h);
    endtask

    task automatic load_result(input logic [23:0] v);
        @(negedge clk);
        result_data  = v;
        result_valid = 1'b1;
        @(negedge clk);
        result_valid = 1'b0;
        mdl_result = v;
        wclk(2);
    endtask

    task automatic check_ports(input string req);
        chk({req, " ctrl_a"}, {88'h0, ctrl_a}, {72'h0, mdl[1]});
        chk({req, " ctrl_c"}, {88'h0, ctrl_c}, {72'h0, mdl[3]});
        chk({req, " gpio"}, {88'h0, gpio_dir, gpio_out}, {72'h0, mdl[2]});
        chk({req, " cal"}, cal_words, {mdl[8], mdl[7], mdl[6], mdl[5]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [23:0] r, v;
        logic h;
        for (int a = 0; a < 16; a++) mdl[a] = '0;
        wclk(4);
        rst_n = 1'b1;
        wclk(4);

        // R1 reset state at the ports
        chk("R1 outputs", {dout, conv_start, pwr_down, ctrl_a, ctrl_c, gpio_dir, gpio_out}, '0);
        chk("R1 cal", cal_words, '0);
        reg_read(4, r, h);
        chk("R1 result word", {72'h0, r}, '0);

        // R4 R5 R6 R7 R8 R11: sweep every address with several patterns
        for (int p = 0; p < 3; p++) begin
            sys_gain_ovr = p[0];
            for (int a = 0; a < 16; a++) begin
                v = 24'((a * 24'h1F3A7) ^ (p * 24'h5A5A5 + 24'h00C3E1));
                reg_write(a, v);
                reg_read(a, r, h);
                chk($sformatf("R5 R6 R7 readback addr %0d", a), {72'h0, r}, {72'h0, expect_read(a)});
                chk("R11 dout low in command byte", {95'h0, h}, '0);
            end
            check_ports("R8 R5 ports");
        end

        // R10 result path, direct load
        load_result(24'hA1B2C3);
        reg_read(4, r, h);
        chk("R10 direct load", {72'h0, r}, {72'h0, 24'hA1B2C3});

        // R10 result arriving during every data bit of a result read
        for (int k = 8; k < 32; k++) begin
            v = 24'(24'h135790 + k * 24'h010203);
            xfer(reg_cmd(1'b1, 4), 24, '0, k, v, -1, r, h);
            chk($sformatf("R10 read whole during bit %0d", k), {72'h0, r}, {72'h0, mdl_result});
            mdl_result = v;
            reg_read(4, r, h);
            chk($sformatf("R10 deferred load bit %0d", k), {72'h0, r}, {72'h0, mdl_result});
        end

        // R10 R9 result read aborted with a held result
        xfer(reg_cmd(1'b1, 4), 24, '0, 12, 24'h0BEEF1, 18, r, h);
        mdl_result = 24'h0BEEF1;
        reg_read(4, r, h);
        chk("R10 release on abort", {72'h0, r}, {72'h0, mdl_result});

        // R9 aborted byte write and aborted word write
        reg_write(2, 24'h00003C);
        xfer(reg_cmd(1'b0, 2), 8, 24'h0000C3, -1, '0, 12, r, h);
        reg_read(2, r, h);
        chk("R9 byte abort", {72'h0, r}, {72'h0, 24'h00003C});
        xfer(reg_cmd(1'b0, 6), 24, 24'hFFFFFF, -1, '0, 30, r, h);
        check_ports("R9 ports after abort");
        reg_write(1, 24'h000011);
        reg_read(1, r, h);
        chk("R9 next command after abort", {72'h0, r}, {72'h0, 24'h000011});

        // R2 start bit zero: a would-be write of ctrl_a is ignored
        xfer(8'h42, 8, 24'h0000FF, -1, '0, -1, r, h);
        xfer(8'h00, 0, '0, -1, '0, -1, r, h);
        check_ports("R2 start bit");
        chk("R2 no strobe", {64'h0, n_conv, n_pdn}, '0);

        // R3 conversion and power-down strobes, trailing bits ignored
        xfer(8'h80, 8, 24'h0000FF, -1, '0, -1, r, h);
        chk("R3 conversion strobe", {64'h0, n_conv, n_pdn}, {64'h0, 32'd1, 32'd0});
        xfer(8'hA0, 8, 24'h0000FF, -1, '0, -1, r, h);
        chk("R3 power-down strobe", {64'h0, n_conv, n_pdn}, {64'h0, 32'd1, 32'd1});
        check_ports("R3 no data phase");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule